// File: doc/BRIEF.md
# Adaptive Turn-Off Delay Controller

This block decides, for one synchronous-rectifier channel, the clock cycle in which the gate should be dropped. It watches the gate state, a flag that the sensed drain-source voltage has reached zero, a fast zero-current comparator flag, and a flag that is high while the body diode conducts. There are two ways it can turn the gate off. The slow path waits a learned number of ticks after the zero crossing. The fast path acts at once when the zero-current flag is raised.

After every turn-off the block counts how long the body diode goes on conducting. It uses that count in two ways. After a slow-path turn-off, the learned delay moves one step toward a target residual time. After a fast-path turn-off, the fast comparator's digital threshold code is raised in proportion to the excess. Separate blanking windows keep either path from acting too soon after turn-on. After reset, and after a wake pulse that marks the end of low-power mode, a few conductions are cut at half the cycle before adaptation takes over. A separate flag tells the driver to stop switching when the measured cycle is too long compared with the resonance period.

All timing is counted in system-clock ticks. The bench counts turn-on as edge 0, which is the first clock edge that samples the gate high. Edge k is the (k+1)-th such edge, and "on count k" means k earlier high samples.

Top module: `tof_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, off_req_o, path_fast_o, thr_code_o and inhibit_o are all 0.
- R2: When zcd_i is sampled high at an edge where the on count is at least FAST_BLANK and no request has been made in this conduction, off_req_o is high for the following cycle and path_fast_o=1 (1 = fast path). A zcd_i sampled at a smaller on count is ignored.
- R3: A zc_i sampled at an on count below period_i>>1 is ignored. If no later zero crossing arrives, no request is made in that conduction.
- R4: Outside start-up mode, a zc_i sampled at edge k, with k ≥ period_i>>1, gives a request registered at edge k+1+D, where D is the learned delay. The request comes with path_fast_o=0, and path_fast_o holds its value until the next request.
- R5: There is at most one request per conduction, and each request lasts one cycle. A request is made only while gate_i is high. When both paths hit at the same edge, the fast path wins.
- R6: The residual time is the number of clock edges, after the edge that first samples gate_i low, at which cond_i is sampled high, up to the first low sample.
- R7: After a slow-path turn-off, D grows by STEP if the residual time is above TARGET and shrinks by STEP if it is below. It is unchanged when the two are equal, and it is saturated to the range 0 to period_i. Turn-offs by other paths leave D unchanged.
- R8: After a fast-path turn-off with a residual time above TARGET, thr_code_o rises by (residual − TARGET) >> GAIN_SH, saturating at its all-ones value. Otherwise it is unchanged. It never decreases.
- R9: After reset, or after a one-cycle wake_i pulse, the next INIT_CYCLES conductions that end in a request are cut at on count period_i>>1, whatever zc_i does. The wake pulse also clears D to 0.
- R10: inhibit_o is registered, and it is 1 exactly when 3·period_i > 5·res_period_i held at the previous edge. That is, the switching frequency is below 60% of the resonance frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_i | input | 1 | Gate currently driven on |
| zc_i | input | 1 | Sensed drain-source voltage has reached zero |
| zcd_i | input | 1 | Fast zero-current comparator fired |
| cond_i | input | 1 | Body diode conducting |
| wake_i | input | 1 | One-cycle pulse on leaving low-power mode |
| period_i | input | TW | Measured cycle length in ticks |
| res_period_i | input | TW | Configured resonance period in ticks |
| off_req_o | output | 1 | One-cycle turn-off request |
| path_fast_o | output | 1 | Path of the last request (1 = fast edge) |
| thr_code_o | output | CW | Threshold code for the fast comparator |
| inhibit_o | output | 1 | Stop driving: frequency too far below resonance |

## Verification
The slow path and the fast path can both reach their decision at the same clock edge. The bench provokes this by placing the zero-current pulse exactly 1+D edges after an accepted zero crossing, where D is the delay the bench has tracked from earlier residual measurements. The result is judged at the ports. There must be a single request with the fast path flag set, and the following slow-path conduction must show that D was not changed by that turn-off. The bench also sweeps both blanking boundaries, both saturation ends of the delay and of the code, and the inhibit ratio on either side of equality.

// File: rtl/tof_pkg.sv
package tof_pkg;
   // Which mechanism produced the turn-off request of a conduction
   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_INIT  = 2'd1,
      KIND_ADAPT = 2'd2,
      KIND_FAST  = 2'd3
   } tof_kind_e;
endpackage

// File: rtl/tof_timer.sv
module tof_timer
   import tof_pkg::*;
#(
   parameter int TW         = 12,
   parameter int FAST_BLANK = 75
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gate_i,
   input  logic          zc_i,
   input  logic          zcd_i,
   input  logic          init_i,
   input  logic [TW-1:0] delay_i,
   input  logic [TW-1:0] period_i,
   output logic          off_req_o,
   output logic          path_fast_o,
   output tof_kind_e     kind_o
);
   localparam logic [TW-1:0] CNT_MAX = '1;
   localparam logic [TW-1:0] FB_V    = TW'(FAST_BLANK);

   logic [TW-1:0] on_cnt, dly_cnt, half;
   logic          zc_seen, done, armed;
   logic          fast_hit, init_hit, adapt_hit, fire;
   tof_kind_e     kind_q;

   always_comb begin
      half      = period_i >> 1;
      armed     = gate_i && !done;
      fast_hit  = armed && zcd_i && (on_cnt >= FB_V);
      init_hit  = armed && init_i && (on_cnt == half);
      adapt_hit = armed && !init_i && zc_seen && (dly_cnt == delay_i);
      fire      = fast_hit || init_hit || adapt_hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on_cnt      <= '0;
         dly_cnt     <= '0;
         zc_seen     <= 1'b0;
         done        <= 1'b0;
         kind_q      <= KIND_NONE;
         off_req_o   <= 1'b0;
         path_fast_o <= 1'b0;
      end else begin
         off_req_o <= fire;
         if (fire) path_fast_o <= fast_hit;
         if (!gate_i) begin
            on_cnt  <= '0;
            dly_cnt <= '0;
            zc_seen <= 1'b0;
            done    <= 1'b0;
            kind_q  <= KIND_NONE;
         end else begin
            if (on_cnt != CNT_MAX) on_cnt <= on_cnt + 1'b1;
            if (!zc_seen && zc_i && (on_cnt >= half)) zc_seen <= 1'b1;
            if (zc_seen && (dly_cnt != CNT_MAX)) dly_cnt <= dly_cnt + 1'b1;
            if (fire) begin
               done <= 1'b1;
               if (fast_hit)      kind_q <= KIND_FAST;
               else if (init_hit) kind_q <= KIND_INIT;
               else               kind_q <= KIND_ADAPT;
            end
         end
      end
   end

   assign kind_o = kind_q;
endmodule

// File: rtl/tof_meter.sv
module tof_meter
   import tof_pkg::*;
#(
   parameter int TW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gate_i,
   input  logic          cond_i,
   input  tof_kind_e     kind_i,
   output logic          res_valid_o,
   output logic [TW-1:0] res_o,
   output tof_kind_e     kind_o
);
   localparam logic [TW-1:0] CNT_MAX = '1;

   logic          gate_q, meas;
   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q      <= 1'b0;
         meas        <= 1'b0;
         cnt         <= '0;
         res_valid_o <= 1'b0;
         res_o       <= '0;
         kind_o      <= KIND_NONE;
      end else begin
         gate_q      <= gate_i;
         res_valid_o <= 1'b0;
         if (gate_q && !gate_i) begin
            meas   <= 1'b1;
            cnt    <= '0;
            kind_o <= kind_i;
         end else if (meas) begin
            if (cond_i) begin
               if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end else begin
               meas        <= 1'b0;
               res_valid_o <= 1'b1;
               res_o       <= cnt;
            end
         end
      end
   end
endmodule

// File: rtl/tof_tuner.sv
module tof_tuner
   import tof_pkg::*;
#(
   parameter int TW          = 12,
   parameter int CW          = 6,
   parameter int TARGET      = 19,
   parameter int STEP        = 1,
   parameter int GAIN_SH     = 1,
   parameter int INIT_CYCLES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wake_i,
   input  logic          res_valid_i,
   input  logic [TW-1:0] res_i,
   input  tof_kind_e     kind_i,
   input  logic [TW-1:0] period_i,
   output logic [TW-1:0] delay_o,
   output logic [CW-1:0] code_o,
   output logic          init_o
);
   localparam int            IW       = $clog2(INIT_CYCLES + 1);
   localparam logic [IW-1:0] INIT_V   = IW'(INIT_CYCLES);
   localparam logic [TW-1:0] TGT_V    = TW'(TARGET);
   localparam logic [TW:0]   STEP_V   = (TW+1)'(STEP);
   localparam logic [CW-1:0] CODE_MAX = '1;

   logic [IW-1:0] init_left;
   logic [TW:0]   up_w, dn_w, sum_w, per_w;
   logic [TW-1:0] up_c, dn_c, excess, inc;
   logic [CW-1:0] code_nx;

   always_comb begin
      per_w  = {1'b0, period_i};
      up_w   = {1'b0, delay_o} + STEP_V;
      up_c   = (up_w > per_w) ? period_i : up_w[TW-1:0];
      dn_w   = ({1'b0, delay_o} >= STEP_V) ? ({1'b0, delay_o} - STEP_V) : '0;
      dn_c   = (dn_w > per_w) ? period_i : dn_w[TW-1:0];
      excess = (res_i > TGT_V) ? (res_i - TGT_V) : '0;
   end

   generate
      if (GAIN_SH == 0) begin : g_gain_unit
         always_comb inc = excess;
      end else begin : g_gain_shift
         always_comb inc = excess >> GAIN_SH;
      end
   endgenerate

   always_comb begin
      sum_w   = (TW+1)'(code_o) + {1'b0, inc};
      code_nx = (sum_w > (TW+1)'(CODE_MAX)) ? CODE_MAX : sum_w[CW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_left <= INIT_V;
         delay_o   <= '0;
         code_o    <= '0;
      end else if (wake_i) begin
         init_left <= INIT_V;
         delay_o   <= '0;
      end else if (res_valid_i) begin
         case (kind_i)
            KIND_ADAPT: begin
               if (res_i > TGT_V)      delay_o <= up_c;
               else if (res_i < TGT_V) delay_o <= dn_c;
            end
            KIND_FAST: code_o <= code_nx;
            default: ;
         endcase
         if ((init_left != '0) && (kind_i != KIND_NONE)) init_left <= init_left - 1'b1;
      end
   end

   assign init_o = (init_left != '0);
endmodule

// File: rtl/tof_ctrl.sv
module tof_ctrl
   import tof_pkg::*;
#(
   parameter int TW          = 12,
   parameter int CW          = 6,
   parameter int FAST_BLANK  = 75,
   parameter int TARGET      = 19,
   parameter int STEP        = 1,
   parameter int GAIN_SH     = 1,
   parameter int INIT_CYCLES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gate_i,
   input  logic          zc_i,
   input  logic          zcd_i,
   input  logic          cond_i,
   input  logic          wake_i,
   input  logic [TW-1:0] period_i,
   input  logic [TW-1:0] res_period_i,
   output logic          off_req_o,
   output logic          path_fast_o,
   output logic [CW-1:0] thr_code_o,
   output logic          inhibit_o
);
   generate
      if (TW < 4)                                       begin : g_bad_tw   $error("TW too small");          end
      if (CW < 1 || CW > TW)                            begin : g_bad_cw   $error("CW must lie in 1..TW");  end
      if (FAST_BLANK < 0 || FAST_BLANK >= (1 << TW))    begin : g_bad_fb   $error("FAST_BLANK out of range"); end
      if (TARGET < 0 || TARGET >= (1 << TW))            begin : g_bad_tg   $error("TARGET out of range");   end
      if (STEP < 1 || STEP >= (1 << TW))                begin : g_bad_st   $error("STEP out of range");     end
      if (GAIN_SH < 0 || GAIN_SH >= TW)                 begin : g_bad_gs   $error("GAIN_SH out of range");  end
      if (INIT_CYCLES < 1)                              begin : g_bad_ic   $error("INIT_CYCLES must be >= 1"); end
   endgenerate

   tof_kind_e     kind_run, kind_meas;
   logic          res_valid, init_mode;
   logic [TW-1:0] res_val, delay_val;
   logic [TW+2:0] per3, res5;

   tof_timer #(.TW(TW), .FAST_BLANK(FAST_BLANK)) u_timer (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .zc_i(zc_i), .zcd_i(zcd_i),
      .init_i(init_mode), .delay_i(delay_val), .period_i(period_i),
      .off_req_o(off_req_o), .path_fast_o(path_fast_o), .kind_o(kind_run)
   );

   tof_meter #(.TW(TW)) u_meter (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .cond_i(cond_i), .kind_i(kind_run),
      .res_valid_o(res_valid), .res_o(res_val), .kind_o(kind_meas)
   );

   tof_tuner #(.TW(TW), .CW(CW), .TARGET(TARGET), .STEP(STEP),
               .GAIN_SH(GAIN_SH), .INIT_CYCLES(INIT_CYCLES)) u_tuner (
      .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .res_valid_i(res_valid),
      .res_i(res_val), .kind_i(kind_meas), .period_i(period_i),
      .delay_o(delay_val), .code_o(thr_code_o), .init_o(init_mode)
   );

   // Cycle longer than 5/3 of resonance period <=> frequency below 60 %
   always_comb begin
      per3 = ({3'b0, period_i} << 1) + {3'b0, period_i};
      res5 = ({3'b0, res_period_i} << 2) + {3'b0, res_period_i};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) inhibit_o <= 1'b0;
      else        inhibit_o <= (per3 > res5);
   end
endmodule

// File: rtl/tof_ctrl_chk.sv
module tof_ctrl_chk #(
   parameter int TW         = 12,
   parameter int CW         = 6,
   parameter int FAST_BLANK = 75
) (
   input logic          clk,
   input logic          rst_n,
   input logic          gate_i,
   input logic [TW-1:0] period_i,
   input logic [TW-1:0] res_period_i,
   input logic          off_req_o,
   input logic          path_fast_o,
   input logic [CW-1:0] thr_code_o,
   input logic          inhibit_o
);
   localparam logic [TW-1:0] HI_MAX = '1;
   localparam logic [TW-1:0] FB_V   = TW'(FAST_BLANK);

   logic [TW-1:0] hi_cnt;
   logic          slow_ratio;

   always_ff @(posedge clk) begin
      if (!rst_n)               hi_cnt <= '0;
      else if (!gate_i)         hi_cnt <= '0;
      else if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
   end

   always_comb slow_ratio = (({3'b0, period_i} << 1) + {3'b0, period_i}) >
                            (({3'b0, res_period_i} << 2) + {3'b0, res_period_i});

   // R2
   fast_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off_req_o && path_fast_o) |-> ($past(hi_cnt) >= FB_V));

   // R3
   slow_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off_req_o && !path_fast_o) |-> ($past(hi_cnt) >= ($past(period_i) >> 1)));

   // R5
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_req_o |=> !off_req_o);

   // R5
   gate_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_req_o |-> $past(gate_i));

   // R8
   code_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(thr_code_o < $past(thr_code_o)));

   // R10
   inhibit_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit_o == $past(slow_ratio));
endmodule

bind tof_ctrl tof_ctrl_chk #(.TW(TW), .CW(CW), .FAST_BLANK(FAST_BLANK)) u_chk (
   .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .period_i(period_i),
   .res_period_i(res_period_i), .off_req_o(off_req_o), .path_fast_o(path_fast_o),
   .thr_code_o(thr_code_o), .inhibit_o(inhibit_o)
);

// File: tb/tb_tof_ctrl.sv
`timescale 1ns/1ps
module tb_tof_ctrl;
   localparam int TW = 10, CW = 4, FB = 5, TGT = 6, STP = 2, GSH = 1, NINIT = 2;
   localparam int KMAX = 60, NOFIRE = 1000, CMAX = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic gate_i = 0, zc_i = 0, zcd_i = 0, cond_i = 0, wake_i = 0;
   logic [TW-1:0] period_i = 10'd40, res_period_i = 10'd40;
   logic off_req_o, path_fast_o, inhibit_o;
   logic [CW-1:0] thr_code_o;

   int total = 0, bad = 0;
   int m_delay = 0, m_code = 0, m_init = NINIT;
   bit finished = 0;

   always #2 clk = ~clk;

   tof_ctrl #(.TW(TW), .CW(CW), .FAST_BLANK(FB), .TARGET(TGT), .STEP(STP),
              .GAIN_SH(GSH), .INIT_CYCLES(NINIT)) dut (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .zc_i(zc_i), .zcd_i(zcd_i),
      .cond_i(cond_i), .wake_i(wake_i), .period_i(period_i), .res_period_i(res_period_i),
      .off_req_o(off_req_o), .path_fast_o(path_fast_o), .thr_code_o(thr_code_o),
      .inhibit_o(inhibit_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One conduction: zc/zcd pulses at on count zc_t/zcd_t (-1 = none), residual res edges
   task automatic conduct(input int zc_t, input int zcd_t, input int res, input string rq);
      int half, fc, ac, ek, got, kind;
      bit gpath;
      half = int'(period_i) >> 1;
      fc = (zcd_t >= FB) ? zcd_t : NOFIRE;
      if (m_init > 0)                         ac = half;
      else if (zc_t >= 0 && zc_t >= half)     ac = zc_t + 1 + m_delay;
      else                                    ac = NOFIRE;
      ek = (fc <= ac) ? fc : ac;
      kind = (ek == NOFIRE) ? 0 : (fc <= ac) ? 3 : (m_init > 0) ? 1 : 2;
      got = NOFIRE; gpath = 0;
      for (int k = 0; k <= KMAX; k++) begin
         gate_i = 1; cond_i = 1;
         zc_i = (k == zc_t); zcd_i = (k == zcd_t);
         @(negedge clk);
         if (off_req_o) begin got = k; gpath = path_fast_o; break; end
      end
      zc_i = 0; zcd_i = 0; gate_i = 0; cond_i = 1;
      chk(got == ek, {rq, " request edge"}, got, ek);
      if (ek != NOFIRE) chk(gpath == (kind == 3), {rq, " path"}, int'(gpath), int'(kind == 3));
      @(negedge clk);
      if (ek != NOFIRE) begin
         chk(off_req_o == 1'b0, "R5 single-cycle request", int'(off_req_o), 0);
         chk(path_fast_o == (kind == 3), "R4 path held", int'(path_fast_o), int'(kind == 3));
      end
      repeat (res) @(negedge clk);
      cond_i = 0;
      repeat (4) @(negedge clk);
      // model update from requirements R6..R9
      if (kind == 2) begin
         if (res > TGT)      m_delay = (m_delay + STP > int'(period_i)) ? int'(period_i) : m_delay + STP;
         else if (res < TGT) m_delay = (m_delay >= STP) ? m_delay - STP : 0;
      end else if (kind == 3 && res > TGT) begin
         m_code = m_code + ((res - TGT) >> GSH);
         if (m_code > CMAX) m_code = CMAX;
      end
      if (kind != 0 && m_init > 0) m_init--;
      chk(int'(thr_code_o) == m_code, "R8 threshold code", int'(thr_code_o), m_code);
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      chk(off_req_o == 0 && path_fast_o == 0, "R1 request/path in reset", int'(off_req_o), 0);
      chk(thr_code_o == 0 && inhibit_o == 0, "R1 code/inhibit in reset", int'(thr_code_o), 0);
      rst_n = 1;
      @(negedge clk);
      chk(off_req_o == 0 && thr_code_o == 0 && inhibit_o == 0, "R1 after release", int'(off_req_o), 0);

      // R9 start-up conductions cut at half period
      conduct(25, -1, 3, "R9 startup");
      conduct(25, -1, 3, "R9 startup");
      // R4 / R6 / R7 slow path learning
      conduct(22, -1, 9, "R4 slow d0");
      conduct(21, -1, 9, "R4 R7 slow d2");
      conduct(25, -1, 2, "R4 R7 slow d4");
      conduct(20, -1, 6, "R4 R6 boundary");
      // R3 slow blank: zero crossings below half are ignored
      conduct(15, -1, 0, "R3 blank");
      conduct(19, -1, 0, "R3 blank edge");
      conduct(30, -1, 0, "R7 shorten");
      conduct(30, -1, 0, "R7 floor");
      conduct(20, -1, 9, "R7 from zero");
      // R2 fast path and its blank
      conduct(-1, 4, 20, "R2 blank");
      conduct(-1, 5, 20, "R2 fast");
      conduct(-1, 8, 6, "R8 equal");
      conduct(-1, 8, 7, "R8 small excess");
      // R5 both paths hit at one edge: fast wins, delay untouched
      conduct(22, 22 + 1 + m_delay, 12, "R5 tie");
      conduct(22, -1, 6, "R5 R7 after tie");
      conduct(-1, 10, 30, "R8 saturate");
      conduct(-1, 12, 40, "R8 held max");
      // R7 upper saturation at the cycle length
      period_i = 10'd8;
      for (int i = 0; i < 7; i++) conduct(4, -1, 10, "R7 ceiling");
      // R9 wake pulse restores start-up placement and clears the delay
      period_i = 10'd40;
      wake_i = 1; @(negedge clk); wake_i = 0;
      m_init = NINIT; m_delay = 0;
      conduct(30, -1, 10, "R9 wake");
      conduct(30, -1, 10, "R9 wake");
      conduct(22, -1, 6, "R9 R7 cleared");
      // R10 inhibit ratio around equality
      res_period_i = 10'd30;
      period_i = 10'd50; repeat (2) @(negedge clk);
      chk(inhibit_o == 0, "R10 ratio equal", int'(inhibit_o), 0);
      period_i = 10'd51; @(negedge clk);
      chk(inhibit_o == 1, "R10 ratio above", int'(inhibit_o), 1);
      period_i = 10'd20; @(negedge clk);
      chk(inhibit_o == 0, "R10 ratio below", int'(inhibit_o), 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule